// File: doc/BRIEF.md
# Element-Width Saturating Result Clamp

This block is the last stage of a vector lane's result path. It receives a result that was computed without any loss of precision and carried as a 72-bit two's-complement number, for instance the output of a float-to-integer conversion. It then fits that result into a destination element whose width can be chosen per operation as 8, 16, 32 or 64 bits. The element is returned zero-extended on a 64-bit bus, one cycle after the input is presented.

Two sources set the range the result must fit into. The first is the signedness of the base operation. The second is a saturation override, which can be off, signed or unsigned. When the override is active, the block treats the input as an exact value and compares it with the intersection of both ranges. An out-of-range value is replaced by the bound it crossed, and a flag reports the replacement. When the override is off, the low bits of the result are kept as they are.

Top module: `elw_sat_clamp`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high `rst` sets `out_valid`, `out_elem` and `out_sat` to 0.
- R2: `width_sel` selects the element width w as 00 = 64, 01 = 32, 10 = 16 and 11 = 8 bits. Every bit of `out_elem` at position w or above is 0.
- R3: `sat_mode` is 00 = off, 01 = signed, 10 = unsigned, and the reserved code 11 behaves as off. When saturation is off, `out_elem` holds the low w bits of `in_value` and `out_sat` is 0.
- R4: With saturation on, the lower bound is the larger of two values. The first is 0 if `op_signed` = 0 and −2^(w−1) if `op_signed` = 1. The second is 0 for mode 10 and −2^(w−1) for mode 01.
- R5: With saturation on, the upper bound is the smaller of two values. The first is 2^w−1 if `op_signed` = 0 and 2^(w−1)−1 if `op_signed` = 1. The second is 2^w−1 for mode 10 and 2^(w−1)−1 for mode 01.
- R6: With saturation on, a value inside the bounds leaves as its low w bits (two's complement), and `out_sat` is 0.
- R7: With saturation on, the comparison uses the full 72-bit signed value, so large values never wrap into range. A value below the lower bound or above the upper bound leaves as the low w bits of that bound, and `out_sat` is 1.
- R8: With an unsigned base operation, a 16-bit element and the signed override, every output lies in 0 to 0x7FFF inclusive.
- R9: In a cycle where `in_valid` is 0, `out_elem` and `out_sat` keep their values at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result is valid this cycle |
| in_value | input | 72 | Exact result, two's complement |
| op_signed | input | 1 | Base operation is signed (1) or unsigned (0) |
| sat_mode | input | 2 | Saturation override: 00 off, 01 signed, 10 unsigned, 11 off |
| width_sel | input | 2 | Element width: 00 = 64, 01 = 32, 10 = 16, 11 = 8 |
| out_valid | output | 1 | Output element is valid |
| out_elem | output | 64 | Clamped element, zero-extended |
| out_sat | output | 1 | Clamping changed the value |

## Verification
The stage has a single register, so any fault shows up at the ports in the cycle right after the input that exposes it. A wrong bound table entry gives a wrong clamped value only for inputs at or just past that bound and at that width, which is why the sweep walks each bound ±1 for every width, signedness and mode. A slip in the comparison width shows up only for inputs far outside the element range, which would wrap into range. A fault in the hold path shows up as a changed element in a cycle with no valid input.

// File: rtl/elw_sat_pkg.sv
package elw_sat_pkg;

  // saturation override encoding
  typedef enum logic [1:0] {
    SAT_OFF      = 2'b00,
    SAT_SIGNED   = 2'b01,
    SAT_UNSIGNED = 2'b10,
    SAT_RSVD     = 2'b11
  } sat_mode_e;

  // element width for a given selector: full width halved per step
  function automatic int elem_width(input int full_w, input int sel);
    return full_w >> sel;
  endfunction

endpackage

// File: rtl/elw_bound_gen.sv
module elw_bound_gen
  import elw_sat_pkg::*;
#(
  parameter int IN_W  = 72,
  parameter int OUT_W = 64,
  parameter int NUM_W = 4,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] width_sel,
  input  logic             op_signed,
  input  logic [1:0]       sat_mode,
  output logic [IN_W-1:0]  lo_bound,
  output logic [IN_W-1:0]  hi_bound,
  output logic             sat_en
);

  localparam logic [IN_W-1:0] ONE = {{(IN_W-1){1'b0}}, 1'b1};

  logic [IN_W-1:0] smin_tab [NUM_W];
  logic [IN_W-1:0] smax_tab [NUM_W];
  logic [IN_W-1:0] umax_tab [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_tab
    localparam int EW = elem_width(OUT_W, g);
    localparam logic [IN_W-1:0] HALF = ONE << (EW - 1);
    assign smax_tab[g] = HALF - ONE;
    assign smin_tab[g] = ~(HALF - ONE);
    assign umax_tab[g] = (ONE << EW) - ONE;
  end

  sat_mode_e mode;
  logic      ovr_signed;
  logic      ovr_unsigned;
  logic      floor_zero;
  logic      ceil_signed;

  always_comb begin
    mode         = sat_mode_e'(sat_mode);
    ovr_signed   = (mode == SAT_SIGNED);
    ovr_unsigned = (mode == SAT_UNSIGNED);
    sat_en       = ovr_signed | ovr_unsigned;
    // larger of the two floors: zero wins if either side is unsigned
    floor_zero   = !op_signed || ovr_unsigned;
    // smaller of the two ceilings: signed max wins if either side is signed
    ceil_signed  = op_signed || ovr_signed;
    lo_bound     = floor_zero  ? '0 : smin_tab[width_sel];
    hi_bound     = ceil_signed ? smax_tab[width_sel] : umax_tab[width_sel];
  end

endmodule

// File: rtl/elw_range_clamp.sv
module elw_range_clamp #(
  parameter int IN_W  = 72,
  parameter int OUT_W = 64
) (
  input  logic [IN_W-1:0]  value,
  input  logic [IN_W-1:0]  lo_bound,
  input  logic [IN_W-1:0]  hi_bound,
  input  logic             sat_en,
  output logic [OUT_W-1:0] clamped,
  output logic             clipped
);

  logic below;
  logic above;

  always_comb begin
    below = sat_en && ($signed(value) < $signed(lo_bound));
    above = sat_en && ($signed(value) > $signed(hi_bound));
    if (below)      clamped = lo_bound[OUT_W-1:0];
    else if (above) clamped = hi_bound[OUT_W-1:0];
    else            clamped = value[OUT_W-1:0];
    clipped = below | above;
  end

endmodule

// File: rtl/elw_elem_pack.sv
module elw_elem_pack
  import elw_sat_pkg::*;
#(
  parameter int OUT_W = 64,
  parameter int NUM_W = 4,
  parameter int SEL_W = 2
) (
  input  logic [OUT_W-1:0] raw,
  input  logic [SEL_W-1:0] width_sel,
  output logic [OUT_W-1:0] elem
);

  logic [OUT_W-1:0] mask_tab [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_mask
    localparam int EW = elem_width(OUT_W, g);
    assign mask_tab[g] = {OUT_W{1'b1}} >> (OUT_W - EW);
  end

  assign elem = raw & mask_tab[width_sel];

endmodule

// File: rtl/elw_sat_clamp.sv
module elw_sat_clamp #(
  parameter int IN_W  = 72,
  parameter int OUT_W = 64,
  parameter int NUM_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_value,
  input  logic             op_signed,
  input  logic [1:0]       sat_mode,
  input  logic [SEL_W-1:0] width_sel,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_elem,
  output logic             out_sat
);

  logic [IN_W-1:0]  lo_bound;
  logic [IN_W-1:0]  hi_bound;
  logic             sat_en;
  logic [OUT_W-1:0] clamped;
  logic             clipped;
  logic [OUT_W-1:0] elem_nxt;

  elw_bound_gen #(
    .IN_W (IN_W),
    .OUT_W(OUT_W),
    .NUM_W(NUM_W),
    .SEL_W(SEL_W)
  ) bound_i (
    .width_sel(width_sel),
    .op_signed(op_signed),
    .sat_mode (sat_mode),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound),
    .sat_en   (sat_en)
  );

  elw_range_clamp #(
    .IN_W (IN_W),
    .OUT_W(OUT_W)
  ) clamp_i (
    .value   (in_value),
    .lo_bound(lo_bound),
    .hi_bound(hi_bound),
    .sat_en  (sat_en),
    .clamped (clamped),
    .clipped (clipped)
  );

  elw_elem_pack #(
    .OUT_W(OUT_W),
    .NUM_W(NUM_W),
    .SEL_W(SEL_W)
  ) pack_i (
    .raw      (clamped),
    .width_sel(width_sel),
    .elem     (elem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_elem  <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_elem <= elem_nxt;
        out_sat  <= clipped;
      end
    end
  end

endmodule

// File: rtl/elw_sat_clamp_chk.sv
module elw_sat_clamp_chk #(
  parameter int IN_W  = 72,
  parameter int OUT_W = 64,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_value,
  input logic             op_signed,
  input logic [1:0]       sat_mode,
  input logic [SEL_W-1:0] width_sel,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_elem,
  input logic             out_sat
);

  function automatic logic [OUT_W-1:0] wmask(input logic [SEL_W-1:0] s);
    int ew;
    ew = OUT_W >> s;
    return {OUT_W{1'b1}} >> (OUT_W - ew);
  endfunction

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_elem & ~wmask($past(width_sel))) == '0));

  // R3
  off_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (sat_mode == 2'b00 || sat_mode == 2'b11)) |=> !out_sat);

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sat ||
      out_elem == ($past(in_value[OUT_W-1:0]) & wmask($past(width_sel)))));

  // R7
  neg_unsigned_clip_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_signed && (sat_mode == 2'b01 || sat_mode == 2'b10) &&
     ($signed(in_value) < 0)) |=> (out_sat && out_elem == '0));

  // R8
  uns_op_sgn_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_signed && sat_mode == 2'b01 && width_sel == 2'b10)
      |=> (out_elem <= OUT_W'(16'h7FFF)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_elem) && $stable(out_sat)));

endmodule

bind elw_sat_clamp elw_sat_clamp_chk #(
  .IN_W (IN_W),
  .OUT_W(OUT_W),
  .SEL_W(SEL_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_value (in_value),
  .op_signed(op_signed),
  .sat_mode (sat_mode),
  .width_sel(width_sel),
  .out_valid(out_valid),
  .out_elem (out_elem),
  .out_sat  (out_sat)
);

// File: tb/elw_sat_clamp_tb_top.sv
`timescale 1ns/1ps
module elw_sat_clamp_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [71:0] in_value = '0;
  logic        op_signed = 1'b0;
  logic [1:0]  sat_mode = 2'b00;
  logic [1:0]  width_sel = 2'b00;
  logic        out_valid;
  logic [63:0] out_elem;
  logic        out_sat;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  elw_sat_clamp dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_value (in_value),
    .op_signed(op_signed),
    .sat_mode (sat_mode),
    .width_sel(width_sel),
    .out_valid(out_valid),
    .out_elem (out_elem),
    .out_sat  (out_sat)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model built from R2..R7
  task automatic model(input logic signed [71:0] v, input int sel, input bit op_s,
                       input int mode, output logic [63:0] e, output logic s);
    logic signed [71:0] one, smin, smax, umax, blo, bhi, olo, ohi, lo, hi, r;
    logic [63:0] mask;
    int w;
    w    = 64 >> sel;
    one  = 72'sd1;
    smin = -(one <<< (w - 1));
    smax = (one <<< (w - 1)) - one;
    umax = (one <<< w) - one;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    if (mode == 0 || mode == 3) begin
      e = v[63:0] & mask;
      s = 1'b0;
    end else begin
      blo = op_s ? smin : 72'sd0;
      bhi = op_s ? smax : umax;
      olo = (mode == 1) ? smin : 72'sd0;
      ohi = (mode == 1) ? smax : umax;
      lo  = (blo > olo) ? blo : olo;
      hi  = (bhi < ohi) ? bhi : ohi;
      r   = (v < lo) ? lo : ((v > hi) ? hi : v);
      s   = (r != v);
      e   = r[63:0] & mask;
    end
  endtask

  function automatic logic signed [71:0] pick(input int k, input int w);
    logic signed [71:0] one;
    one = 72'sd1;
    case (k)
      0:  return 72'sd0;
      1:  return 72'sd1;
      2:  return -72'sd1;
      3:  return -(one <<< (w - 1));
      4:  return -(one <<< (w - 1)) - one;
      5:  return (one <<< (w - 1)) - one;
      6:  return (one <<< (w - 1));
      7:  return (one <<< w) - one;
      8:  return (one <<< w);
      9:  return (one <<< 71) - one;
      10: return -(one <<< 71);
      default: return 72'sh5A_A5C3_3C96_69F0_0F12;
    endcase
  endfunction

  // present one input, then sample on the next falling edge
  task automatic apply(input logic [71:0] v, input bit op_s, input int mode, input int sel,
                       input string req);
    logic [63:0] e;
    logic s;
    @(negedge clk);
    in_value  = v;
    op_signed = op_s;
    sat_mode  = mode[1:0];
    width_sel = sel[1:0];
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(v, sel, op_s, mode, e, s);
    check({"R1 out_valid ", req}, {63'd0, out_valid}, 64'd1);
    check({"elem ", req}, out_elem, e);
    check({"flag ", req}, {63'd0, out_sat}, {63'd0, s});
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic held_s;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset elem", out_elem, 64'd0);
    check("R1 reset flag", {63'd0, out_sat}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // sweep widths (R2), modes incl. reserved (R3), bounds (R4, R5), inside (R6), outside (R7)
    for (int sel = 0; sel < 4; sel++) begin
      for (int op = 0; op < 2; op++) begin
        for (int mode = 0; mode < 4; mode++) begin
          for (int k = 0; k < 12; k++) begin
            apply(pick(k, 64 >> sel), op[0], mode, sel, "R2 R3 R4 R5 R6 R7 sweep");
            // R9: idle cycle with changed input must leave outputs alone
            held = out_elem;
            held_s = out_sat;
            in_value = ~in_value;
            @(negedge clk);
            check("R9 hold elem", out_elem, held);
            check("R9 hold flag", {63'd0, out_sat}, {63'd0, held_s});
            check("R1 idle valid", {63'd0, out_valid}, 64'd0);
          end
        end
      end
    end

    // R8: unsigned base, 16-bit element, signed override
    apply(72'h0_0000_0000_0001_2345, 1'b0, 1, 2, "R8 big");
    check("R8 big value", out_elem, 64'h7FFF);
    apply(-72'sd5, 1'b0, 1, 2, "R8 negative");
    check("R8 negative value", out_elem, 64'h0);
    apply(72'h0_0000_0000_0000_7FFF, 1'b0, 1, 2, "R8 edge");
    check("R8 edge flag", {63'd0, out_sat}, 64'd0);

    // R7: far out-of-range value at 8 bits, must not wrap
    apply(72'h1_0000_0000_0000_0005, 1'b1, 1, 3, "R7 no wrap");
    check("R7 no wrap value", out_elem, 64'h7F);

    // R3: reserved mode keeps low bits only
    apply(72'hF_FFFF_FFFF_FFFF_1234, 1'b1, 3, 2, "R3 reserved");
    check("R3 reserved value", out_elem, 64'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule